// File: doc/BRIEF.md
# Paged ISA Window Bridge

This block connects a small 8-bit host bus with 16 address lines to a 24-bit ISA-style expansion bus. The host sees a 1 KB region. That region is split into four 256-byte ranges, and the top range is a window onto the ISA bus. Host address bits 7:0 reach the ISA address bus directly. The higher ISA address bits come from page registers that software writes before it opens the window. A mode bit chooses what a window access becomes. It is either an ISA I/O cycle or an ISA memory cycle. For memory cycles, the address decides the strobe pair. The short-range pair is used inside the first megabyte and the full-range pair above it.

The other ranges of the region work as follows:
- The range just below the window holds the control registers: two page bytes and the mode bit.
- The lowest range stages the upper data byte for 16-bit window writes.
- The range above it returns the upper data byte captured during the last window read.

All command strobes are qualified by the host phase-2 clock, so they appear only in the valid half of a host cycle. The ISA reset is the active-high copy of the host's active-low reset. Address enable is held low, and the ISA address-latch and clock pins follow phase 2. Register updates are taken on the system clock `clk` while phase 2 is high.

Top module: `isa_window_bridge`

## Requirements
- R1: `isa_addr[7:0]` always equals `host_addr[7:0]`.
- R2: A host write of byte D at region offset 0x200 sets `isa_addr[15:8]` to D. A write at offset 0x201 sets `isa_addr[23:16]` to D. Reading either offset returns the stored byte on `host_rdata`.
- R3: Bit 0 of the register at offset 0x202 is the mode bit. When it is 1, window reads assert `isa_ior_n` and window writes assert `isa_iow_n`, both active low. The register reads back its value.
- R4: In memory mode, `isa_addr[23:20]` selects the strobe. When those bits are zero, a window read asserts `isa_smemr_n` and a window write asserts `isa_smemw_n`. Otherwise a read asserts `isa_memr_n` and a write asserts `isa_memw_n`. At most one strobe is low at any time.
- R5: A command strobe is low only while all of the following hold:
  - `host_phi2` is high,
  - `host_sel` is high,
  - `host_addr[9:8]` is 3,
  - the strobe's direction matches `host_rw` (1 = read).
- R6: While `host_rst_n` is low, and after it rises, the page bytes and the mode bit are zero. This selects memory space at ISA page zero.
- R7: Offsets 0x000 to 0x2FF, and any cycle with `host_sel` low, produce no ISA command strobe.
- R8: A write at offset 0x000 stores a byte. That byte is driven on `isa_dout[15:8]` during window writes, and `isa_doe` is high exactly during a window write. A read at offset 0x000 clears the stored byte to zero.
- R9: Every window read returns `isa_din[7:0]` on `host_rdata` and captures `isa_din[15:8]`. A read at offset 0x100 returns the captured byte. A write at offset 0x100 has no effect.
- R10: `isa_reset` is the inverse of `host_rst_n`, and `isa_aen` is 0. `isa_bale` and `isa_clk` equal `host_phi2`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for register updates |
| host_rst_n | input | 1 | Host reset, active low |
| host_sel | input | 1 | Host 1 KB region select, active high |
| host_addr | input | 10 | Offset inside the host region |
| host_rw | input | 1 | Host direction, 1 = read |
| host_phi2 | input | 1 | Host phase-2 clock level |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data |
| host_rdata_oe | output | 1 | Host read data valid and driven |
| isa_addr | output | 24 | ISA address bus |
| isa_dout | output | 16 | ISA write data |
| isa_doe | output | 1 | ISA data bus drive enable |
| isa_din | input | 16 | ISA read data |
| isa_ior_n | output | 1 | ISA I/O read strobe |
| isa_iow_n | output | 1 | ISA I/O write strobe |
| isa_smemr_n | output | 1 | ISA memory read strobe, first megabyte |
| isa_smemw_n | output | 1 | ISA memory write strobe, first megabyte |
| isa_memr_n | output | 1 | ISA memory read strobe, above first megabyte |
| isa_memw_n | output | 1 | ISA memory write strobe, above first megabyte |
| isa_reset | output | 1 | ISA reset, active high |
| isa_aen | output | 1 | ISA address enable, held low |
| isa_bale | output | 1 | ISA address latch enable |
| isa_clk | output | 1 | ISA bus clock |

## Verification
The hardest case to reach is the exact boundary between the two memory strobe pairs. The page bytes must first be written so that the address sits at the first megabyte, and then at just below it. The stimulus first writes a high page byte of 0x10 and opens the window, which must give the full-range read strobe. It then rewrites that byte to 0x0F and opens the window again, which must give the short-range write strobe. The captured upper data lane is also indirect to observe. The bench places a known word on the ISA input during a window read, clears the input, and reads the capture range. It then writes that range and reads it again to show the write is ignored.

// File: rtl/isa_bridge_pkg.sv
package isa_bridge_pkg;

    // Sub-range of the host region, selected by host_addr[9:8]
    typedef enum logic [1:0] {
        RGN_LANE_OUT = 2'd0,
        RGN_LANE_IN  = 2'd1,
        RGN_CTRL     = 2'd2,
        RGN_WINDOW   = 2'd3
    } region_e;

    // Qualified host accesses (phase 2 high, region selected)
    typedef struct packed {
        logic win_rd;
        logic win_wr;
        logic ctrl_rd;
        logic ctrl_wr;
        logic lout_rd;
        logic lout_wr;
        logic lin_rd;
        logic lin_wr;
    } access_t;

    // ISA command strobes, active high inside the block
    typedef struct packed {
        logic ior;
        logic iow;
        logic smemr;
        logic smemw;
        logic memr;
        logic memw;
    } strobes_t;

endpackage

// File: rtl/isa_region_decode.sv
module isa_region_decode
    import isa_bridge_pkg::*;
#(
    parameter int HOST_AW = 10
) (
    input  logic               sel,
    input  logic               phi2,
    input  logic               rw,
    input  logic [HOST_AW-1:0] addr,
    output access_t            acc
);
    region_e rgn;
    logic    live;

    always_comb begin
        rgn  = region_e'(addr[HOST_AW-1 -: 2]);
        live = sel & phi2;
        acc  = '0;
        unique case (rgn)
            RGN_WINDOW: begin
                acc.win_rd = live & rw;
                acc.win_wr = live & ~rw;
            end
            RGN_CTRL: begin
                acc.ctrl_rd = live & rw;
                acc.ctrl_wr = live & ~rw;
            end
            RGN_LANE_IN: begin
                acc.lin_rd = live & rw;
                acc.lin_wr = live & ~rw;
            end
            default: begin
                acc.lout_rd = live & rw;
                acc.lout_wr = live & ~rw;
            end
        endcase
    end
endmodule

// File: rtl/isa_page_regs.sv
module isa_page_regs
    import isa_bridge_pkg::*;
#(
    parameter int ISA_AW      = 24,
    parameter int WIN_AW      = 8,
    parameter int HOST_DW     = 8,
    parameter int FULL_DECODE = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  access_t                  acc,
    input  logic [WIN_AW-1:0]        idx,
    input  logic [HOST_DW-1:0]       wdata,
    input  logic [HOST_DW-1:0]       din_hi,
    output logic [ISA_AW-WIN_AW-1:0] page,
    output logic                     io_mode,
    output logic [HOST_DW-1:0]       lane_out,
    output logic [HOST_DW-1:0]       lane_in,
    output logic [HOST_DW-1:0]       ctrl_rdata
);
    localparam int PAGE_W     = ISA_AW - WIN_AW;
    localparam int PAGE_BYTES = PAGE_W / HOST_DW;
    localparam int REACH_AW   = (FULL_DECODE != 0 || ISA_AW < 21) ? ISA_AW : 21;
    localparam logic [PAGE_W-1:0] PAGE_MASK =
        PAGE_W'((64'd1 << (REACH_AW - WIN_AW)) - 64'd1);
    localparam logic [WIN_AW-1:0] MODE_IDX = WIN_AW'(PAGE_BYTES);

    typedef struct packed {
        logic [PAGE_W-1:0]  page;
        logic               io_mode;
        logic [HOST_DW-1:0] lane_out;
        logic [HOST_DW-1:0] lane_in;
    } state_t;

    state_t state_d, state_q;
    logic [HOST_DW-1:0] page_byte [PAGE_BYTES];

    for (genvar b = 0; b < PAGE_BYTES; b++) begin : g_page_byte
        assign page_byte[b] = state_q.page[b*HOST_DW +: HOST_DW];
    end

    always_comb begin
        state_d = state_q;
        if (acc.ctrl_wr) begin
            for (int b = 0; b < PAGE_BYTES; b++) begin
                if (idx == WIN_AW'(b)) begin
                    state_d.page[b*HOST_DW +: HOST_DW] = wdata;
                end
            end
            if (idx == MODE_IDX) begin
                state_d.io_mode = wdata[0];
            end
        end
        state_d.page = state_d.page & PAGE_MASK;
        if (acc.lout_wr) begin
            state_d.lane_out = wdata;
        end else if (acc.lout_rd) begin
            state_d.lane_out = '0;
        end
        if (acc.win_rd) begin
            state_d.lane_in = din_hi;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        ctrl_rdata = '0;
        for (int b = 0; b < PAGE_BYTES; b++) begin
            if (idx == WIN_AW'(b)) begin
                ctrl_rdata = page_byte[b];
            end
        end
        if (idx == MODE_IDX) begin
            ctrl_rdata = {{(HOST_DW-1){1'b0}}, state_q.io_mode};
        end
    end

    assign page     = state_q.page;
    assign io_mode  = state_q.io_mode;
    assign lane_out = state_q.lane_out;
    assign lane_in  = state_q.lane_in;
endmodule

// File: rtl/isa_strobe_gen.sv
module isa_strobe_gen
    import isa_bridge_pkg::*;
#(
    parameter int ISA_AW = 24
) (
    input  logic              win_rd,
    input  logic              win_wr,
    input  logic              io_mode,
    input  logic [ISA_AW-1:0] addr,
    output strobes_t          stb
);
    localparam int MB_BIT = 20;
    localparam int TOP_W  = ISA_AW - MB_BIT;

    logic first_mb;

    always_comb begin
        first_mb  = (addr[ISA_AW-1 -: TOP_W] == '0);
        stb       = '0;
        stb.ior   = io_mode & win_rd;
        stb.iow   = io_mode & win_wr;
        stb.smemr = ~io_mode & first_mb & win_rd;
        stb.smemw = ~io_mode & first_mb & win_wr;
        stb.memr  = ~io_mode & ~first_mb & win_rd;
        stb.memw  = ~io_mode & ~first_mb & win_wr;
    end
endmodule

// File: rtl/isa_window_bridge.sv
module isa_window_bridge
    import isa_bridge_pkg::*;
#(
    parameter int HOST_AW     = 10,
    parameter int HOST_DW     = 8,
    parameter int WIN_AW      = 8,
    parameter int ISA_AW      = 24,
    parameter int FULL_DECODE = 1
) (
    input  logic                 clk,
    input  logic                 host_rst_n,
    input  logic                 host_sel,
    input  logic [HOST_AW-1:0]   host_addr,
    input  logic                 host_rw,
    input  logic                 host_phi2,
    input  logic [HOST_DW-1:0]   host_wdata,
    output logic [HOST_DW-1:0]   host_rdata,
    output logic                 host_rdata_oe,
    output logic [ISA_AW-1:0]    isa_addr,
    output logic [2*HOST_DW-1:0] isa_dout,
    output logic                 isa_doe,
    input  logic [2*HOST_DW-1:0] isa_din,
    output logic                 isa_ior_n,
    output logic                 isa_iow_n,
    output logic                 isa_smemr_n,
    output logic                 isa_smemw_n,
    output logic                 isa_memr_n,
    output logic                 isa_memw_n,
    output logic                 isa_reset,
    output logic                 isa_aen,
    output logic                 isa_bale,
    output logic                 isa_clk
);
    localparam int PAGE_W = ISA_AW - WIN_AW;

    access_t              acc;
    strobes_t             stb;
    logic [PAGE_W-1:0]    page;
    logic                 io_mode;
    logic [HOST_DW-1:0]   lane_out;
    logic [HOST_DW-1:0]   lane_in;
    logic [HOST_DW-1:0]   ctrl_rdata;

    isa_region_decode #(.HOST_AW(HOST_AW)) u_decode (
        .sel  (host_sel),
        .phi2 (host_phi2),
        .rw   (host_rw),
        .addr (host_addr),
        .acc  (acc)
    );

    isa_page_regs #(
        .ISA_AW      (ISA_AW),
        .WIN_AW      (WIN_AW),
        .HOST_DW     (HOST_DW),
        .FULL_DECODE (FULL_DECODE)
    ) u_regs (
        .clk        (clk),
        .rst_n      (host_rst_n),
        .acc        (acc),
        .idx        (host_addr[WIN_AW-1:0]),
        .wdata      (host_wdata),
        .din_hi     (isa_din[2*HOST_DW-1:HOST_DW]),
        .page       (page),
        .io_mode    (io_mode),
        .lane_out   (lane_out),
        .lane_in    (lane_in),
        .ctrl_rdata (ctrl_rdata)
    );

    assign isa_addr = {page, host_addr[WIN_AW-1:0]};

    isa_strobe_gen #(.ISA_AW(ISA_AW)) u_strobe (
        .win_rd  (acc.win_rd),
        .win_wr  (acc.win_wr),
        .io_mode (io_mode),
        .addr    (isa_addr),
        .stb     (stb)
    );

    assign isa_ior_n   = ~stb.ior;
    assign isa_iow_n   = ~stb.iow;
    assign isa_smemr_n = ~stb.smemr;
    assign isa_smemw_n = ~stb.smemw;
    assign isa_memr_n  = ~stb.memr;
    assign isa_memw_n  = ~stb.memw;

    assign isa_dout = {lane_out, host_wdata};
    assign isa_doe  = acc.win_wr;

    always_comb begin
        host_rdata = '0;
        if (acc.win_rd) begin
            host_rdata = isa_din[HOST_DW-1:0];
        end else if (acc.ctrl_rd) begin
            host_rdata = ctrl_rdata;
        end else if (acc.lin_rd) begin
            host_rdata = lane_in;
        end
        host_rdata_oe = acc.win_rd | acc.ctrl_rd | acc.lin_rd | acc.lout_rd;
    end

    assign isa_reset = ~host_rst_n;
    assign isa_aen   = 1'b0;
    assign isa_bale  = host_phi2;
    assign isa_clk   = host_phi2;
endmodule

// File: rtl/isa_window_bridge_chk.sv
module isa_window_bridge_chk #(
    parameter int HOST_AW = 10,
    parameter int HOST_DW = 8,
    parameter int ISA_AW  = 24
) (
    input logic               clk,
    input logic               host_rst_n,
    input logic               host_sel,
    input logic [HOST_AW-1:0] host_addr,
    input logic               host_rw,
    input logic               host_phi2,
    input logic [HOST_DW-1:0] host_wdata,
    input logic [ISA_AW-1:0]  isa_addr,
    input logic               isa_doe,
    input logic               isa_ior_n,
    input logic               isa_iow_n,
    input logic               isa_smemr_n,
    input logic               isa_smemw_n,
    input logic               isa_memr_n,
    input logic               isa_memw_n
);
    logic [5:0] act;
    logic       any_rd;
    logic       any_wr;

    assign act    = ~{isa_ior_n, isa_iow_n, isa_smemr_n, isa_smemw_n, isa_memr_n, isa_memw_n};
    assign any_rd = act[5] | act[3] | act[1];
    assign any_wr = act[4] | act[2] | act[0];

    // R4: never more than one command strobe
    assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!host_rst_n)
        $countones(act) <= 1);

    // R4: short-range strobes only inside the first megabyte
    assert_short_low_R4: assert property (@(posedge clk) disable iff (!host_rst_n)
        (act[3] | act[2]) |-> (isa_addr[ISA_AW-1:20] == '0));

    // R4: full-range strobes only above the first megabyte
    assert_full_high_R4: assert property (@(posedge clk) disable iff (!host_rst_n)
        (act[1] | act[0]) |-> (isa_addr[ISA_AW-1:20] != '0));

    // R5: strobes only inside the valid phase on a window access
    assert_strobe_window_R5: assert property (@(posedge clk) disable iff (!host_rst_n)
        (act != '0) |-> (host_phi2 && host_sel && host_addr[HOST_AW-1 -: 2] == 2'b11));

    // R5: strobe direction follows host_rw
    assert_strobe_dir_R5: assert property (@(posedge clk) disable iff (!host_rst_n)
        (any_rd |-> host_rw) and (any_wr |-> !host_rw));

    // R7: deselected host produces no strobe
    assert_no_strobe_unsel_R7: assert property (@(posedge clk) disable iff (!host_rst_n)
        !host_sel |-> (act == '0));

    // R2: low page write lands on isa_addr[15:8] next cycle
    assert_page_load_R2: assert property (@(posedge clk) disable iff (!host_rst_n)
        (host_sel && host_phi2 && !host_rw && host_addr == HOST_AW'(10'h200))
        |=> (isa_addr[15:8] == $past(host_wdata)));

    // R8: data drive only together with a write strobe
    assert_drive_with_write_R8: assert property (@(posedge clk) disable iff (!host_rst_n)
        isa_doe |-> any_wr);
endmodule

bind isa_window_bridge isa_window_bridge_chk u_chk (.*);

// File: tb/sim_isa_window_bridge.sv
`timescale 1ns/1ps
module sim_isa_window_bridge;
    logic        clk = 1'b0;
    logic        host_rst_n = 1'b0;
    logic        host_sel = 1'b0;
    logic [9:0]  host_addr = '0;
    logic        host_rw = 1'b1;
    logic        host_phi2 = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        host_rdata_oe;
    logic [23:0] isa_addr;
    logic [15:0] isa_dout;
    logic        isa_doe;
    logic [15:0] isa_din = '0;
    logic isa_ior_n, isa_iow_n, isa_smemr_n, isa_smemw_n, isa_memr_n, isa_memw_n;
    logic isa_reset, isa_aen, isa_bale, isa_clk;

    always #2.5 clk = ~clk;

    isa_window_bridge u0 (.*);

    // observation vector layout
    localparam logic [63:0] M_ALO = 64'h00FF;
    localparam logic [63:0] M_AHI = 64'hFF_FF00;
    localparam logic [63:0] M_STB = 64'h3F << 24;
    localparam logic [63:0] M_RD  = 64'hFF << 30;
    localparam logic [63:0] M_DHI = 64'hFF << 38;
    localparam logic [63:0] M_DOE = 64'h1 << 46;
    localparam logic [63:0] M_PINS = 64'hF << 47;

    localparam logic [5:0] S_NONE  = 6'b111111;
    localparam logic [5:0] S_IOR   = 6'b011111;
    localparam logic [5:0] S_IOW   = 6'b101111;
    localparam logic [5:0] S_SMEMR = 6'b110111;
    localparam logic [5:0] S_SMEMW = 6'b111011;
    localparam logic [5:0] S_MEMR  = 6'b111101;
    localparam logic [5:0] S_MEMW  = 6'b111110;

    typedef struct {
        string       req;
        logic [63:0] mask;
        logic [63:0] exp;
    } item_t;

    item_t q[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    function automatic logic [63:0] obs_now();
        return {13'd0, isa_clk, isa_bale, isa_aen, isa_reset, isa_doe, isa_dout[15:8],
                host_rdata, isa_ior_n, isa_iow_n, isa_smemr_n, isa_smemw_n,
                isa_memr_n, isa_memw_n, isa_addr};
    endfunction

    function automatic logic [63:0] mk(logic [23:0] a, logic [5:0] s, logic [7:0] rd,
                                       logic [7:0] dhi, logic doe, logic [3:0] pins);
        return {13'd0, pins, doe, dhi, rd, s, a};
    endfunction

    task automatic expect_obs(string req, logic [63:0] mask, logic [63:0] exp);
        item_t it;
        it.req = req; it.mask = mask; it.exp = exp;
        q.push_back(it);
    endtask

    // monitor: compares queued expectations mid-cycle
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0) begin
                item_t it;
                logic [63:0] o;
                it = q.pop_front();
                o = obs_now();
                checks++;
                if (((o ^ it.exp) & it.mask) != 0) begin
                    errors++;
                    $display("FAIL %s actual=%h expected=%h", it.req, o & it.mask, it.exp & it.mask);
                end
            end
        end
    end

    task automatic apply(logic sel, logic [9:0] a, logic rw, logic [7:0] d, logic phi);
        @(posedge clk); #1;
        host_sel = sel; host_addr = a; host_rw = rw; host_wdata = d; host_phi2 = phi;
    endtask

    task automatic idle();
        apply(1'b0, 10'h000, 1'b1, 8'h00, 1'b0);
    endtask

    task automatic wr_reg(logic [9:0] a, logic [7:0] d);
        apply(1'b1, a, 1'b0, d, 1'b1);
        idle();
    endtask

    task automatic rd_check(string req, logic [9:0] a, logic [7:0] exp);
        apply(1'b1, a, 1'b1, 8'h00, 1'b1);
        expect_obs(req, M_RD | M_STB, mk('0, S_NONE, exp, 8'h00, 1'b0, 4'h0));
        idle();
    endtask

    initial begin
        // R6 R10: reset state
        apply(1'b0, 10'h0AB, 1'b1, 8'h00, 1'b0);
        expect_obs("R6 R10 reset", M_AHI | M_STB | M_PINS,
                   mk(24'h0000AB, S_NONE, 8'h00, 8'h00, 1'b0, 4'b0001));
        @(posedge clk); #1 host_rst_n = 1'b1;

        // R1 R7 R10: passthrough, deselected, pins follow phi2
        apply(1'b0, 10'h05A, 1'b1, 8'h00, 1'b1);
        expect_obs("R1 R7 R10 idle", M_ALO | M_STB | M_PINS,
                   mk(24'h00005A, S_NONE, 8'h00, 8'h00, 1'b0, 4'b1100));

        // R5: phase low gives no strobe; R4 R6: page zero memory read
        apply(1'b1, 10'h3C3, 1'b1, 8'h00, 1'b0);
        expect_obs("R5 phi2 low", M_STB, mk('0, S_NONE, 8'h00, 8'h00, 1'b0, 4'h0));
        apply(1'b1, 10'h3C3, 1'b1, 8'h00, 1'b1);
        expect_obs("R4 R6 smemr page0", M_ALO | M_AHI | M_STB,
                   mk(24'h0000C3, S_SMEMR, 8'h00, 8'h00, 1'b0, 4'h0));
        idle();

        // R2: page bytes
        wr_reg(10'h200, 8'h12);
        wr_reg(10'h201, 8'h34);
        apply(1'b0, 10'h000, 1'b1, 8'h00, 1'b0);
        expect_obs("R2 page on bus", M_AHI, mk(24'h341200, S_NONE, 8'h00, 8'h00, 1'b0, 4'h0));
        rd_check("R2 readback lo", 10'h200, 8'h12);
        rd_check("R2 readback hi", 10'h201, 8'h34);

        // R4: above the first megabyte
        apply(1'b1, 10'h3FF, 1'b0, 8'h77, 1'b1);
        expect_obs("R4 memw high", M_ALO | M_AHI | M_STB,
                   mk(24'h3412FF, S_MEMW, 8'h00, 8'h00, 1'b0, 4'h0));
        idle();
        wr_reg(10'h201, 8'h10);
        apply(1'b1, 10'h300, 1'b1, 8'h00, 1'b1);
        expect_obs("R4 memr at 1MB", M_STB, mk('0, S_MEMR, 8'h00, 8'h00, 1'b0, 4'h0));
        idle();
        wr_reg(10'h201, 8'h0F);
        apply(1'b1, 10'h300, 1'b0, 8'h00, 1'b1);
        expect_obs("R4 smemw below 1MB", M_STB, mk('0, S_SMEMW, 8'h00, 8'h00, 1'b0, 4'h0));
        idle();

        // R3: I/O mode
        wr_reg(10'h202, 8'h01);
        rd_check("R3 mode readback", 10'h202, 8'h01);
        apply(1'b1, 10'h310, 1'b1, 8'h00, 1'b1);
        expect_obs("R3 ior", M_STB, mk('0, S_IOR, 8'h00, 8'h00, 1'b0, 4'h0));
        apply(1'b1, 10'h310, 1'b0, 8'h00, 1'b1);
        expect_obs("R3 iow", M_STB, mk('0, S_IOW, 8'h00, 8'h00, 1'b0, 4'h0));
        idle();
        wr_reg(10'h202, 8'h00);

        // R8: staged upper byte
        wr_reg(10'h000, 8'hA5);
        apply(1'b1, 10'h320, 1'b0, 8'h3C, 1'b1);
        expect_obs("R8 upper lane drive", M_DHI | M_DOE,
                   mk('0, S_NONE, 8'h00, 8'hA5, 1'b1, 4'h0));
        apply(1'b1, 10'h320, 1'b1, 8'h00, 1'b1);
        expect_obs("R8 no drive on read", M_DOE, mk('0, S_NONE, 8'h00, 8'h00, 1'b0, 4'h0));
        idle();
        apply(1'b1, 10'h000, 1'b1, 8'h00, 1'b1);
        idle();
        apply(1'b1, 10'h320, 1'b0, 8'h3C, 1'b1);
        expect_obs("R8 cleared by read", M_DHI | M_DOE,
                   mk('0, S_NONE, 8'h00, 8'h00, 1'b1, 4'h0));
        idle();

        // R9: captured upper byte
        isa_din = 16'hBEEF;
        apply(1'b1, 10'h340, 1'b1, 8'h00, 1'b1);
        expect_obs("R9 window read data", M_RD, mk('0, S_NONE, 8'hEF, 8'h00, 1'b0, 4'h0));
        idle();
        isa_din = 16'h0000;
        rd_check("R9 capture readback", 10'h100, 8'hBE);
        wr_reg(10'h100, 8'h11);
        rd_check("R9 write ignored", 10'h100, 8'hBE);

        // R7: non-window ranges and deselect
        apply(1'b0, 10'h3C0, 1'b1, 8'h00, 1'b1);
        expect_obs("R7 deselected window", M_STB, mk('0, S_NONE, 8'h00, 8'h00, 1'b0, 4'h0));
        apply(1'b1, 10'h2C0, 1'b0, 8'h55, 1'b1);
        expect_obs("R7 ctrl range", M_STB | M_DOE, mk('0, S_NONE, 8'h00, 8'h00, 1'b0, 4'h0));
        idle();

        // R6: reset clears page and mode
        @(posedge clk); #1 host_rst_n = 1'b0;
        @(posedge clk); #1 host_rst_n = 1'b1;
        apply(1'b0, 10'h000, 1'b1, 8'h00, 1'b0);
        expect_obs("R6 page cleared", M_AHI | M_PINS, mk('0, S_NONE, 8'h00, 8'h00, 1'b0, 4'h0));
        rd_check("R6 mode cleared", 10'h202, 8'h00);

        repeat (3) @(posedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule